// File: doc/BRIEF.md
# Triple-Modulus Frequency Divider

This block divides a fast input clock by 64, 65 or 72. A front stage counts input cycles four or five at a time. A cycle counter advances once per front-stage cycle and sets the length of each output period. The counter uses the front-stage carry as a synchronous enable, so every register sits on the single input clock.

Two control bits choose the ratio. They are sampled only on the edge that ends a period, so a change always applies to a whole period. Each output period starts with the output going low. The output goes high on the 32nd input cycle counted from the period start, and it stays high until the period ends. A terminal-count strobe marks the last input cycle of every period, for use by a loop controller that adjusts the ratio from one period to the next.

Top module: `tmd_divider`

## Requirements
- R1: With mod_a=1 and mod_b=0, every output period lasts 64 input cycles.
- R2: With mod_a=0 and mod_b=0, every output period lasts 65 input cycles. The single extra cycle is added by the front stage counting to five, and only during the last counter step of the period.
- R3: With mod_b=1, every output period lasts 72 input cycles, whatever the value of mod_a. The front stage counts four and the counter spans 18 steps.
- R4: Number the input cycles of a period from 0 to N-1. div_out is low for cycles 0 to 31 and high for cycles 32 to N-1. It falls on the first cycle of each period and rises 32 cycles after the period starts.
- R5: tc_pulse is high during cycle N-1 of every period and low during all other cycles.
- R6: mod_a and mod_b are sampled only on the rising edge that ends a period. Changes at any other time have no effect on the length of the current period.
- R7: rst_n is an active-low synchronous reset. It clears both counters and holds div_out and tc_pulse low. mod_a and mod_b are sampled on every reset edge. The first input cycle after reset is released is cycle 0 of a period whose length is set by the last values sampled during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock; the divider advances on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mod_a | input | 1 | Modulus control bit: 1 selects 64 and 0 selects 65, when mod_b is 0 |
| mod_b | input | 1 | Modulus control bit: 1 selects 72 |
| div_out | output | 1 | Divided output, low for the first 32 cycles of each period |
| tc_pulse | output | 1 | High during the last input cycle of each period |

## Verification
The assertions assume that mod_a, mod_b and rst_n are synchronous to clk_in and settle before each rising edge. Under that assumption, the counter state seen at each edge is well defined. The bench changes every input only at falling edges of clk_in, so each input value is held across a full rising edge. It also switches the control bits in the middle of periods and applies reset partway through a period. This covers every transition between each pair of control settings.

// File: rtl/tmd_pkg.sv
package tmd_pkg;

  typedef enum logic [1:0] {
    MODE_64 = 2'd0,
    MODE_65 = 2'd1,
    MODE_72 = 2'd2
  } tmd_mode_e;

  function automatic tmd_mode_e tmd_decode(input logic sel_a, input logic sel_b);
    if (sel_b)      return MODE_72;
    else if (sel_a) return MODE_64;
    else            return MODE_65;
  endfunction

endpackage

// File: rtl/tmd_front_div.sv
module tmd_front_div #(
  parameter int BASE = 4,
  parameter int W    = 3
) (
  input  logic         clk_in,
  input  logic         rst_n,
  input  logic         five,
  output logic [W-1:0] pre_q,
  output logic         carry
);

  logic [W-1:0] last_val;

  assign last_val = five ? W'(BASE) : W'(BASE - 1);
  assign carry    = (pre_q == last_val);

  always_ff @(posedge clk_in) begin
    if (!rst_n)     pre_q <= '0;
    else if (carry) pre_q <= '0;
    else            pre_q <= pre_q + 1'b1;
  end

  AST_PRE_RANGE: assert property (@(posedge clk_in) disable iff (!rst_n)
    !five |-> (pre_q < W'(BASE))) else $error("front stage beyond base count"); // R2

endmodule

// File: rtl/tmd_cycle_cnt.sv
module tmd_cycle_cnt #(
  parameter int W = 5
) (
  input  logic         clk_in,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] last_val,
  output logic [W-1:0] cnt_q,
  output logic         at_last
);

  assign at_last = (cnt_q == last_val);

  always_ff @(posedge clk_in) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk_in) disable iff (!rst_n)
    cnt_q <= last_val) else $error("cycle counter past its limit"); // R3

endmodule

// File: rtl/tmd_mod_ctl.sv
module tmd_mod_ctl
  import tmd_pkg::*;
#(
  parameter int CNT_SHORT = 16,
  parameter int CNT_LONG  = 18,
  parameter int W         = 5
) (
  input  logic         clk_in,
  input  logic         rst_n,
  input  logic         sel_a,
  input  logic         sel_b,
  input  logic         period_end,
  output logic [W-1:0] last_val,
  output logic         swallow_en
);

  tmd_mode_e mode_q;

  always_ff @(posedge clk_in) begin
    if (!rst_n || period_end) mode_q <= tmd_decode(sel_a, sel_b);
  end

  assign last_val   = (mode_q == MODE_72) ? W'(CNT_LONG - 1) : W'(CNT_SHORT - 1);
  assign swallow_en = (mode_q == MODE_65);

  AST_MODE_HOLD: assert property (@(posedge clk_in) disable iff (!rst_n)
    !period_end |=> $stable(mode_q)) else $error("ratio changed mid-period"); // R6

endmodule

// File: rtl/tmd_divider.sv
module tmd_divider #(
  parameter int PRE_BASE  = 4,
  parameter int CNT_SHORT = 16,
  parameter int CNT_LONG  = 18,
  parameter int RISE_IDX  = 32
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic mod_a,
  input  logic mod_b,
  output logic div_out,
  output logic tc_pulse
);

  localparam int PRE_W    = $clog2(PRE_BASE + 2);
  localparam int CNT_W    = $clog2(CNT_LONG + 1);
  localparam int RISE_CNT = (RISE_IDX - 1) / PRE_BASE;
  localparam int RISE_PRE = (RISE_IDX - 1) % PRE_BASE;

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;
  logic             carry;
  logic             cnt_last;
  logic             swallow_en;
  logic             five;
  logic             tc;
  logic             rise_hit;
  logic             out_q;

  assign five     = swallow_en && cnt_last;
  assign tc       = carry && cnt_last;
  assign rise_hit = (cnt_q == CNT_W'(RISE_CNT)) && (pre_q == PRE_W'(RISE_PRE));

  tmd_mod_ctl #(
    .CNT_SHORT (CNT_SHORT),
    .CNT_LONG  (CNT_LONG),
    .W         (CNT_W)
  ) u_mod (
    .clk_in     (clk_in),
    .rst_n      (rst_n),
    .sel_a      (mod_a),
    .sel_b      (mod_b),
    .period_end (tc),
    .last_val   (last_val),
    .swallow_en (swallow_en)
  );

  tmd_front_div #(
    .BASE (PRE_BASE),
    .W    (PRE_W)
  ) u_front (
    .clk_in (clk_in),
    .rst_n  (rst_n),
    .five   (five),
    .pre_q  (pre_q),
    .carry  (carry)
  );

  tmd_cycle_cnt #(
    .W (CNT_W)
  ) u_cnt (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .step     (carry),
    .last_val (last_val),
    .cnt_q    (cnt_q),
    .at_last  (cnt_last)
  );

  always_ff @(posedge clk_in) begin
    if (!rst_n)        out_q <= 1'b0;
    else if (tc)       out_q <= 1'b0;
    else if (rise_hit) out_q <= 1'b1;
  end

  assign div_out  = out_q;
  assign tc_pulse = tc;

  AST_FALL_AT_END: assert property (@(posedge clk_in) disable iff (!rst_n)
    tc |=> (!out_q && $past(out_q))) else $error("output did not fall at period end"); // R4

  AST_RISE_POINT: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(out_q) |-> (cnt_q == CNT_W'(RISE_CNT + 1) && pre_q == '0)) else $error("output rose at wrong count"); // R4

  AST_TC_SINGLE: assert property (@(posedge clk_in) disable iff (!rst_n)
    tc |=> !tc) else $error("terminal count longer than one cycle"); // R5

endmodule

// File: tb/tmd_divider_tb.sv
`timescale 1ns/1ps
module tmd_divider_tb_top;

  logic clk_in = 1'b0;
  logic rst_n  = 1'b0;
  logic mod_a  = 1'b1;
  logic mod_b  = 1'b0;
  logic div_out;
  logic tc_pulse;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int p = 0;
  int n_cur = 64;
  int cyc = 0;
  int per_start = 0;
  logic prev_out = 1'b0;

  always #4 clk_in = ~clk_in;

  tmd_divider dut_i (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .mod_a    (mod_a),
    .mod_b    (mod_b),
    .div_out  (div_out),
    .tc_pulse (tc_pulse)
  );

  function automatic int exp_len(input logic a, input logic b);
    if (b)      return 72;
    else if (a) return 64;
    else        return 65;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One input cycle: the model advances with the inputs held over the
  // preceding rising edge, then outputs are compared at the falling edge.
  task automatic step(input string len_req);
    logic r, a, b;
    int   old_start, old_n;
    r = rst_n; a = mod_a; b = mod_b;
    @(negedge clk_in);
    cyc++;
    if (!r) begin
      p = 0; n_cur = exp_len(a, b); per_start = cyc; prev_out = 1'b0;
      chk("R7", "div_out in reset", int'(div_out), 0);
      chk("R7", "tc_pulse in reset", int'(tc_pulse), 0);
      return;
    end
    old_start = per_start; old_n = n_cur;
    if (p == n_cur - 1) begin
      p = 0; n_cur = exp_len(a, b); per_start = cyc;
    end else begin
      p++;
    end
    chk("R4", "div_out level", int'(div_out), (p >= 32) ? 1 : 0);
    chk("R5", "tc_pulse level", int'(tc_pulse), (p == n_cur - 1) ? 1 : 0);
    if (prev_out && !div_out)
      chk(len_req, "period length", cyc - old_start, old_n);
    if (!prev_out && div_out)
      chk("R4", "rise offset", cyc - per_start, 32);
    prev_out = div_out;
  endtask

  task automatic run_periods(input int np, input string req);
    int ends = 0;
    while (ends < np) begin
      step(req);
      if (p == 0) ends++;
    end
  endtask

  task automatic step_until(input int idx, input string req);
    step(req);
    while (p != idx) step(req);
  endtask

  initial begin
    repeat (3) step("R7");
    rst_n = 1'b1;
    // R7: the first period after reset uses the setting sampled during reset
    run_periods(3, "R1");
    mod_a = 1'b0; mod_b = 1'b0;
    run_periods(3, "R2");
    mod_a = 1'b0; mod_b = 1'b1;
    run_periods(3, "R3");
    mod_a = 1'b1; mod_b = 1'b1;
    run_periods(3, "R3");

    // R6: toggle controls mid-period, restore before the period ends
    for (int s = 0; s < 4; s++) begin
      mod_a = s[0]; mod_b = s[1];
      run_periods(1, "R6");
      step_until(10, "R6");
      mod_a = ~s[0]; mod_b = ~s[1];
      step_until(40, "R6");
      mod_a = s[0]; mod_b = s[1];
      run_periods(1, "R6");
    end

    // Sweep every pair of settings across a period boundary
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        mod_a = f[0]; mod_b = f[1];
        run_periods(2, "R6");
        mod_a = t[0]; mod_b = t[1];
        run_periods(2, (t[1]) ? "R3" : (t[0] ? "R1" : "R2"));
      end
    end

    // R7: reset partway through a period, then a 65 period first
    mod_a = 1'b0; mod_b = 1'b0;
    step_until(45, "R7");
    rst_n = 1'b0;
    mod_a = 1'b1;
    step("R7");
    mod_a = 1'b0;
    step("R7");
    rst_n = 1'b1;
    mod_a = 1'b1; mod_b = 1'b1;
    run_periods(1, "R7");
    run_periods(2, "R3");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule